// File: doc/BRIEF.md
# Power-Down Clock Stop Sequencer

This block sits between a set of free-running clock sources and the clock pins of a clock generator. It gates each source into an output, and it drives the enable lines of the crystal oscillator and the VCO. An asynchronous active-low power-down request starts a shutdown sequence. Every gated output stops low at a falling edge of its own clock. Each output cell reports its stopped state back to the reference domain. Only when all outputs report stopped does the block drop the VCO enable, and the oscillator enable drops one reference cycle after that.

Releasing the request runs the sequence in the opposite order. The oscillator enable rises first and the VCO enable follows one cycle later. The outputs stay parked for a parameterized number of reference cycles and are then released, again on falling edges. While running, a register bank can disable single outputs, two stop lines can hold the CPU group or the PCI group low, and a global control can drive every pad enable inactive to float the outputs. Source 0 is the reference clock, and the sequencer runs on it.

Top module: `clk_stop_seq`

## Requirements
- R1: Right after reset, osc_en, vco_en and every clk_out bit are 0. With pwrdn_n high, the block then performs the wake-up sequence by itself.
- R2: pwrdn_n passes through a two-stage synchronizer on the reference clock. After pwrdn_n falls, the reference output still produces at least two rising edges.
- R3: An output only starts or stops at a falling edge of its own source. Every high phase seen on clk_out[i] lasts a full source half period, so no runt pulse appears on entry to or exit from power-down, or when an output is gated.
- R4: vco_en falls only after every output, the reference output included, is parked low. osc_en falls exactly one reference cycle after vco_en. No clk_out bit is high while either enable is low.
- R5: While powered down, osc_en and vco_en stay 0 and every clk_out bit stays 0.
- R6: On release, osc_en rises first and vco_en rises exactly one reference cycle later. All outputs then remain low for at least SETTLE_CYCLES-1 further reference cycles, and each enabled output runs again within a bounded number of cycles after that.
- R7: out_en[i] = 1 lets output i run. out_en[i] = 0 holds clk_out[i] low with no edges.
- R8: hiz_all = 1 drives every clk_oe bit to 0 (outputs floated). hiz_all = 0 drives every clk_oe bit to 1.
- R9: cpu_stop_n = 0 holds the outputs selected by CPU_MASK (bits 1 and 2 by default) low, and pci_stop_n = 0 does the same for PCI_MASK (bit 3 by default). Outputs outside the mask keep running. Both lines have no effect while powered down.
- R10: If power-down is requested again during the settling wait, no output is released. vco_en falls before osc_en, and the block returns to the powered-down state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | NUM_CLK | Free-running clock sources; bit 0 is the reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Asynchronous active-low power-down request |
| cpu_stop_n | input | 1 | Active-low stop for the CPU output group |
| pci_stop_n | input | 1 | Active-low stop for the PCI output group |
| out_en | input | NUM_CLK | Per-output enable from the register bank |
| hiz_all | input | 1 | 1 floats all outputs |
| clk_out | output | NUM_CLK | Gated clock outputs |
| clk_oe | output | NUM_CLK | Pad output enables, 1 = driven |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The hardest situation to reach is a power-down request that arrives in the middle of the settling wait. The outputs are still parked at that point, but the VCO is already on. The bench gets there by releasing pwrdn_n, watching for osc_en to rise, and pulling pwrdn_n low again a few reference cycles later. It then confirms that no output edge appeared and that the enables fall in the correct order. A second hard case is a slow source whose stop takes several reference cycles. A 40 ns source stretches the stopped handshake, and a background monitor flags any output activity while either enable is low.

// File: rtl/clkseq_pkg.sv
`timescale 1ns/1ps
package clkseq_pkg;

    typedef enum logic [2:0] {
        ST_DOWN    = 3'd0,
        ST_OSC_ON  = 3'd1,
        ST_SETTLE  = 3'd2,
        ST_RUN     = 3'd3,
        ST_PARK    = 3'd4,
        ST_VCO_OFF = 3'd5
    } seq_state_e;

endpackage

// File: rtl/clkseq_sync.sv
`timescale 1ns/1ps
module clkseq_sync #(
    parameter int                WIDTH     = 1,
    parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [WIDTH-1:0] st1;
        logic [WIDTH-1:0] st2;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d.st1 = d;
        r_d.st2 = r_q.st1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st1 <= RESET_VAL;
            r_q.st2 <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign q = r_q.st2;

endmodule

// File: rtl/clkseq_gate.sv
`timescale 1ns/1ps
module clkseq_gate (
    input  logic clk_src,
    input  logic rst_n,
    input  logic run_req,
    output logic clk_out,
    output logic en_o
);

    logic run_s;
    logic en_d, en_q;

    clkseq_sync #(
        .WIDTH     (1),
        .RESET_VAL (1'b0)
    ) u_run_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d     (run_req),
        .q     (run_s)
    );

    always_comb begin
        en_d = run_s;
    end

    // Enable changes only while the source is low, so the AND below cannot glitch.
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else begin
            en_q <= en_d;
        end
    end

    assign clk_out = clk_src & en_q;
    assign en_o    = en_q;

    // R3: the gate enable seen at a rising edge is the synchronized request of that edge's half period
    a_r3_gate_tracks_request: assert property (
        @(posedge clk_src) disable iff (!rst_n) en_q == run_s
    );

endmodule

// File: rtl/clkseq_ctrl.sv
`timescale 1ns/1ps
module clkseq_ctrl
    import clkseq_pkg::*;
#(
    parameter int                  NUM_CLK       = 7,
    parameter int                  SETTLE_CYCLES = 32,
    parameter int                  PARK_GUARD    = 16,
    parameter logic [NUM_CLK-1:0]  CPU_MASK      = NUM_CLK'(6),
    parameter logic [NUM_CLK-1:0]  PCI_MASK      = NUM_CLK'(8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_req,
    input  logic               cpu_stop,
    input  logic               pci_stop,
    input  logic [NUM_CLK-1:0] out_en,
    input  logic [NUM_CLK-1:0] parked,
    output logic [NUM_CLK-1:0] run_o,
    output logic               osc_en,
    output logic               vco_en
);

    localparam int CNT_MAX = (SETTLE_CYCLES > PARK_GUARD) ? SETTLE_CYCLES : PARK_GUARD;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CW-1:0]    cnt;
        logic [NUM_CLK-1:0] run;
        logic             osc_en;
        logic             vco_en;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       all_parked;
    logic [NUM_CLK-1:0] stop_mask;

    assign all_parked = &parked;
    assign stop_mask  = (cpu_stop ? CPU_MASK : '0) | (pci_stop ? PCI_MASK : '0);

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_DOWN: begin
                if (!pd_req) r_d.state = ST_OSC_ON;
            end
            ST_OSC_ON: begin
                if (pd_req) begin
                    r_d.state = ST_DOWN;
                end else begin
                    r_d.state = ST_SETTLE;
                    r_d.cnt   = '0;
                end
            end
            ST_SETTLE: begin
                if (pd_req) begin
                    r_d.state = ST_VCO_OFF;
                end else if (r_q.cnt == CW'(SETTLE_CYCLES - 1)) begin
                    r_d.state = ST_RUN;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_RUN: begin
                if (pd_req) begin
                    r_d.state = ST_PARK;
                    r_d.cnt   = '0;
                end
            end
            ST_PARK: begin
                if ((r_q.cnt >= CW'(PARK_GUARD - 1)) && all_parked) begin
                    r_d.state = ST_VCO_OFF;
                end else if (r_q.cnt < CW'(PARK_GUARD - 1)) begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_VCO_OFF: begin
                r_d.state = ST_DOWN;
            end
            default: begin
                r_d.state = ST_DOWN;
            end
        endcase

        r_d.osc_en = (r_d.state != ST_DOWN);
        r_d.vco_en = (r_d.state == ST_SETTLE) || (r_d.state == ST_RUN) || (r_d.state == ST_PARK);
        r_d.run    = (r_d.state == ST_RUN) ? (out_en & ~stop_mask) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state  <= ST_DOWN;
            r_q.cnt    <= '0;
            r_q.run    <= '0;
            r_q.osc_en <= 1'b0;
            r_q.vco_en <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign run_o  = r_q.run;
    assign osc_en = r_q.osc_en;
    assign vco_en = r_q.vco_en;

    // R4: the VCO is only switched off after the stopped reports from every output
    a_r4_vco_off_after_parked: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(r_q.vco_en) |-> $past(all_parked)
    );

    // R4: the oscillator never stops while the VCO was still on
    a_r4_osc_off_after_vco: assert property (
        @(posedge clk) disable iff (!rst_n) $fell(r_q.osc_en) |-> $past(!r_q.vco_en)
    );

    // R6: the VCO only starts once the oscillator is already running
    a_r6_vco_on_after_osc: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(r_q.vco_en) |-> $past(r_q.osc_en)
    );

    // R5: no output is requested unless both sources are up
    a_r5_run_needs_sources: assert property (
        @(posedge clk) disable iff (!rst_n) (r_q.run != '0) |-> (r_q.vco_en && r_q.osc_en)
    );

    // R10: a request seen during settling never lets an output start on the next cycle
    a_r10_abort_keeps_parked: assert property (
        @(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SETTLE && pd_req) |=> (r_q.run == '0)
    );

endmodule

// File: rtl/clk_stop_seq.sv
`timescale 1ns/1ps
module clk_stop_seq #(
    parameter int                  NUM_CLK       = 7,
    parameter int                  SETTLE_CYCLES = 32,
    parameter int                  PARK_GUARD    = 16,
    parameter logic [NUM_CLK-1:0]  CPU_MASK      = NUM_CLK'(6),
    parameter logic [NUM_CLK-1:0]  PCI_MASK      = NUM_CLK'(8)
) (
    input  logic [NUM_CLK-1:0] clk_src,
    input  logic               rst_n,
    input  logic               pwrdn_n,
    input  logic               cpu_stop_n,
    input  logic               pci_stop_n,
    input  logic [NUM_CLK-1:0] out_en,
    input  logic               hiz_all,
    output logic [NUM_CLK-1:0] clk_out,
    output logic [NUM_CLK-1:0] clk_oe,
    output logic               osc_en,
    output logic               vco_en
);

    localparam int REF_IDX = 0;

    logic               ref_clk;
    logic [2:0]         ctl_s;
    logic [NUM_CLK-1:0] run_req;
    logic [NUM_CLK-1:0] gate_en;
    logic [NUM_CLK-1:0] gate_en_s;

    assign ref_clk = clk_src[REF_IDX];

    // {pci_stop_n, cpu_stop_n, pwrdn_n}; power-down is assumed during reset
    clkseq_sync #(
        .WIDTH     (3),
        .RESET_VAL (3'b110)
    ) u_ctl_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     ({pci_stop_n, cpu_stop_n, pwrdn_n}),
        .q     (ctl_s)
    );

    clkseq_sync #(
        .WIDTH     (NUM_CLK),
        .RESET_VAL ('0)
    ) u_fb_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (gate_en),
        .q     (gate_en_s)
    );

    clkseq_ctrl #(
        .NUM_CLK       (NUM_CLK),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .PARK_GUARD    (PARK_GUARD),
        .CPU_MASK      (CPU_MASK),
        .PCI_MASK      (PCI_MASK)
    ) u_ctrl (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .pd_req   (~ctl_s[0]),
        .cpu_stop (~ctl_s[1]),
        .pci_stop (~ctl_s[2]),
        .out_en   (out_en),
        .parked   (~gate_en_s),
        .run_o    (run_req),
        .osc_en   (osc_en),
        .vco_en   (vco_en)
    );

    for (genvar gi = 0; gi < NUM_CLK; gi++) begin : g_gate
        clkseq_gate u_gate (
            .clk_src (clk_src[gi]),
            .rst_n   (rst_n),
            .run_req (run_req[gi]),
            .clk_out (clk_out[gi]),
            .en_o    (gate_en[gi])
        );
    end

    assign clk_oe = hiz_all ? '0 : '1;

    // R5: with the oscillator off, no output may be high
    a_r5_quiet_when_down: assert property (
        @(posedge ref_clk) disable iff (!rst_n) !osc_en |-> (clk_out == '0)
    );

endmodule

// File: tb/clk_stop_seq_test.sv
`timescale 1ns/100ps
module clk_stop_seq_test;

    localparam int N      = 7;
    localparam int SETTLE = 32;
    localparam int GUARD  = 16;
    localparam int HALF [N] = '{10, 3, 6, 15, 7, 20, 11};

    logic [N-1:0] clk_src;
    logic         rst_n;
    logic         pwrdn_n;
    logic         cpu_stop_n;
    logic         pci_stop_n;
    logic [N-1:0] out_en;
    logic         hiz_all;
    logic [N-1:0] clk_out;
    logic [N-1:0] clk_oe;
    logic         osc_en;
    logic         vco_en;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int unsigned rises [N];
    int unsigned hi_w  [N];
    int          runt_cnt  = 0;
    int          order_viol = 0;

    for (genvar gi = 0; gi < N; gi++) begin : g_clk
        logic c;
        initial begin
            c = 1'b0;
            forever #(HALF[gi]) c = ~c;
        end
        assign clk_src[gi] = c;
    end

    clk_stop_seq #(
        .NUM_CLK       (N),
        .SETTLE_CYCLES (SETTLE),
        .PARK_GUARD    (GUARD)
    ) uut (
        .clk_src    (clk_src),
        .rst_n      (rst_n),
        .pwrdn_n    (pwrdn_n),
        .cpu_stop_n (cpu_stop_n),
        .pci_stop_n (pci_stop_n),
        .out_en     (out_en),
        .hiz_all    (hiz_all),
        .clk_out    (clk_out),
        .clk_oe     (clk_oe),
        .osc_en     (osc_en),
        .vco_en     (vco_en)
    );

    // Background monitor: rising edges, high-phase widths, activity with a source off
    initial begin
        logic [N-1:0] prev;
        prev = '0;
        for (int i = 0; i < N; i++) begin
            rises[i] = 0;
            hi_w[i]  = 0;
        end
        #0.5;
        forever begin
            for (int i = 0; i < N; i++) begin
                if (clk_out[i] && !prev[i]) begin
                    rises[i]++;
                    hi_w[i] = 1;
                end else if (clk_out[i]) begin
                    hi_w[i]++;
                end else if (prev[i]) begin
                    if (hi_w[i] < HALF[i]) runt_cnt++;
                end
            end
            if ((!vco_en || !osc_en) && (clk_out != '0)) order_viol++;
            prev = clk_out;
            #1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic neg(input int n);
        repeat (n) @(negedge clk_src[0]);
    endtask

    task automatic window(input int ns, output int unsigned d [N]);
        int unsigned s [N];
        for (int i = 0; i < N; i++) s[i] = rises[i];
        #(ns);
        for (int i = 0; i < N; i++) d[i] = rises[i] - s[i];
    endtask

    // Waits for osc_en, then checks enable order, settle silence and restart (R6)
    task automatic do_wake(input string req);
        int           n;
        int unsigned  d [N];
        bit           quiet;
        n = 0;
        while (!osc_en && n < 60) begin
            neg(1);
            n++;
        end
        chk(osc_en == 1'b1, req, "osc_en rises after release", osc_en, 1);
        chk(vco_en == 1'b0, "R6", "vco_en still low when osc_en first seen", vco_en, 0);
        neg(1);
        chk(vco_en == 1'b1, "R6", "vco_en one cycle after osc_en", vco_en, 1);
        quiet = 1;
        for (int k = 0; k < SETTLE - 1; k++) begin
            neg(1);
            if (clk_out != '0) quiet = 0;
        end
        chk(quiet, "R6", "outputs parked during settle", quiet, 1);
        window(400, d);
        for (int i = 0; i < N; i++)
            chk(d[i] > 0, "R6", $sformatf("output %0d restarted", i), d[i], 1);
    endtask

    task automatic t_reset();
        chk(osc_en == 1'b0 && vco_en == 1'b0, "R1", "enables in reset", {osc_en, vco_en}, 0);
        chk(clk_out == '0, "R1", "outputs in reset", clk_out, 0);
        neg(1);
        rst_n = 1'b1;
        neg(1);
        chk(osc_en == 1'b0, "R1", "osc_en right after reset", osc_en, 0);
        chk(clk_out == '0, "R1", "outputs right after reset", clk_out, 0);
        do_wake("R1");
    endtask

    task automatic t_enter_pd();
        int unsigned d [N];
        int n;
        neg(1);
        pwrdn_n = 1'b0;
        window(45, d);
        chk(d[0] >= 2, "R2", "reference edges after request", d[0], 2);
        n = 0;
        while (vco_en && n < 200) begin
            neg(1);
            n++;
        end
        chk(vco_en == 1'b0, "R4", "vco_en falls", vco_en, 0);
        chk(n >= GUARD - 3, "R4", "cycles from request to vco off", n, GUARD);
        chk(osc_en == 1'b1, "R4", "osc_en still high at vco fall", osc_en, 1);
        chk(clk_out == '0, "R4", "outputs parked at vco fall", clk_out, 0);
        neg(1);
        chk(osc_en == 1'b0, "R4", "osc_en one cycle after vco_en", osc_en, 0);
        window(400, d);
        for (int i = 0; i < N; i++)
            chk(d[i] == 0, "R5", $sformatf("output %0d quiet in power-down", i), d[i], 0);
        chk(osc_en == 1'b0 && vco_en == 1'b0, "R5", "enables held off", {osc_en, vco_en}, 0);
        chk(order_viol == 0, "R4", "output activity with a source off", order_viol, 0);
        chk(runt_cnt == 0, "R3", "runt pulses on entry", runt_cnt, 0);
    endtask

    task automatic t_stops_in_pd();
        int unsigned d [N];
        cpu_stop_n = 1'b0;
        pci_stop_n = 1'b0;
        neg(10);
        window(300, d);
        chk(d[1] == 0 && d[3] == 0 && d[0] == 0, "R9", "stop lines ignored while down",
            d[0] + d[1] + d[3], 0);
        chk(osc_en == 1'b0 && vco_en == 1'b0, "R9", "enables unchanged by stop lines",
            {osc_en, vco_en}, 0);
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b1;
        neg(5);
    endtask

    task automatic t_exit_pd();
        neg(1);
        pwrdn_n = 1'b1;
        do_wake("R6");
        chk(runt_cnt == 0, "R3", "runt pulses on exit", runt_cnt, 0);
    endtask

    task automatic t_out_en();
        int unsigned d [N];
        out_en[3] = 1'b0;
        neg(12);
        window(300, d);
        chk(d[3] == 0, "R7", "disabled output held low", d[3], 0);
        chk(d[0] > 0 && d[4] > 0, "R7", "other outputs keep running", d[0], 1);
        out_en[3] = 1'b1;
        neg(12);
        window(300, d);
        chk(d[3] > 0, "R7", "re-enabled output runs", d[3], 1);
    endtask

    task automatic t_stops_in_run();
        int unsigned d [N];
        cpu_stop_n = 1'b0;
        neg(12);
        window(300, d);
        chk(d[1] == 0 && d[2] == 0, "R9", "cpu group stopped", d[1] + d[2], 0);
        chk(d[3] > 0, "R9", "pci output runs under cpu stop", d[3], 1);
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b0;
        neg(12);
        window(300, d);
        chk(d[3] == 0, "R9", "pci group stopped", d[3], 0);
        chk(d[1] > 0 && d[2] > 0, "R9", "cpu group runs under pci stop", d[1], 1);
        pci_stop_n = 1'b1;
        neg(12);
        chk(runt_cnt == 0, "R3", "runt pulses on group gating", runt_cnt, 0);
    endtask

    task automatic t_hiz();
        hiz_all = 1'b1;
        #1;
        chk(clk_oe == '0, "R8", "pads floated", clk_oe, 0);
        hiz_all = 1'b0;
        #1;
        chk(clk_oe == '1, "R8", "pads driven", clk_oe, (1 << N) - 1);
    endtask

    task automatic t_abort();
        int unsigned s [N];
        int n;
        int unsigned tot;
        neg(1);
        pwrdn_n = 1'b0;
        n = 0;
        while (osc_en && n < 200) begin
            neg(1);
            n++;
        end
        for (int i = 0; i < N; i++) s[i] = rises[i];
        pwrdn_n = 1'b1;
        n = 0;
        while (!osc_en && n < 60) begin
            neg(1);
            n++;
        end
        neg(5);
        pwrdn_n = 1'b0;
        n = 0;
        while (osc_en && n < 60) begin
            neg(1);
            n++;
        end
        chk(osc_en == 1'b0 && vco_en == 1'b0, "R10", "back to powered down",
            {osc_en, vco_en}, 0);
        neg(SETTLE + 10);
        tot = 0;
        for (int i = 0; i < N; i++) tot += rises[i] - s[i];
        chk(tot == 0, "R10", "no output released by aborted wake", tot, 0);
        chk(order_viol == 0, "R10", "enable order on abort", order_viol, 0);
        neg(1);
        pwrdn_n = 1'b1;
        do_wake("R10");
    endtask

    initial begin
        #(3_000_000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        pwrdn_n    = 1'b1;
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b1;
        out_en     = '1;
        hiz_all    = 1'b0;
        neg(5);
        t_reset();
        t_hiz();
        t_enter_pd();
        t_stops_in_pd();
        t_exit_pd();
        t_out_en();
        t_stops_in_run();
        t_abort();
        chk(runt_cnt == 0, "R3", "runt pulses overall", runt_cnt, 0);
        chk(order_viol == 0, "R4", "activity with a source off overall", order_viol, 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule